// File: doc/BRIEF.md
# Read-only two-wire converter slave

This block is the bus-side front end of a single-channel 14-bit sampling converter. It listens on an open-drain two-wire bus (clock and data), and when it sees its own address it acknowledges and asks the conversion engine for a sample. While the engine works, the block holds the bus clock low. When the result arrives it lets the clock go and shifts the result out as two bytes. The master keeps the stream going by acknowledging each pair of bytes. A not-acknowledge ends the read.

The seven-bit address is a fixed upper field of binary 011 followed by four strap inputs, so up to sixteen such slaves can share one bus. The direction bit of the address byte is not needed for direction, because this slave is always read. Its value is kept as a flag that tells the analog side whether to keep its reference powered. The block also recognises the high-speed master code, answers it with a not-acknowledge and tracks the bus speed mode. Both lines are sampled through synchronizers on the system clock. The outputs are drive-low enables only.

Top module: `conv_rd_slave`

## Requirements
- R1: An address byte equal to {3'b011, strap[3:0]} in bits 7..1 (bit 7 sent first) is answered with ACK: SDA is low throughout the high phase of the 9th clock.
- R2: An address byte that matches neither the slave address nor the master code gets no ACK and starts no conversion. The slave then leaves SDA undriven for the rest of the transfer until the next START.
- R3: After an accepted address byte, conv_start pulses for exactly one cycle at the 9th SCL fall. From that cycle scl_pull stays asserted until the cycle after conv_done, when it is released.
- R4: conv_data[15:2] is the 14-bit result and conv_data[1:0] holds the sub-bits S1,S0. The first byte read is conv_data[15:8] and the second is conv_data[7:0]. Each byte is sent MSB first.
- R5: If the master ACKs the second byte, another conversion starts at once, with stretching as in R3. If the master NACKs it, the read ends with SCL and SDA released and no further conversion.
- R6: If the master NACKs the first byte, the read ends there. No second byte is driven and no conversion starts.
- R7: A byte whose bits 7..3 are 00001 (the master code) gets NACK, and hs_mode becomes 1 at the 9th SCL fall.
- R8: hs_mode is 0 after reset. It stays 1 across repeated STARTs and returns to 0 on a STOP.
- R9: On an accepted address, ref_keep_on takes the value of the address byte's bit 0 (0 = power the reference down after conversion). Its reset value is 1, and a non-matching address leaves it unchanged.
- R10: sda_pull changes only while SCL is low, except when a START or STOP clears it.
- R11: A START seen in the middle of a byte abandons that byte. The address that follows is received from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| scl_pull | output | 1 | When 1, the pad pulls the bus clock low (stretch) |
| sda_pull | output | 1 | When 1, the pad pulls the bus data low |
| strap | input | 4 | Low four bits of the slave address |
| conv_start | output | 1 | One-cycle request to the conversion engine |
| conv_done | input | 1 | One-cycle pulse, result valid on conv_data |
| conv_data | input | 16 | Result bits 15..2, sub-bits 1..0 |
| hs_mode | output | 1 | Bus is in high-speed mode |
| ref_keep_on | output | 1 | Latched bit 0 of the last accepted address byte |

## Verification
A wrong state register shows on the bus within one SCL period. A missed address decode turns the 9th-clock sample high instead of low. A wrong byte counter makes the slave drive data during a master acknowledge slot, or lets a data byte run one bit long, so the next byte comes out shifted. A stuck stretch flag hangs the master's next rising clock, which shows up as a hang. A stale mode flag shows on hs_mode within a few system cycles of the STOP or of the 9th falling edge.

// File: rtl/conv_rd_pkg.sv
package conv_rd_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ADDR  = 3'd1,
        S_AACK  = 3'd2,
        S_MCODE = 3'd3,
        S_CONV  = 3'd4,
        S_TX    = 3'd5,
        S_RACK  = 3'd6
    } st_e;

    localparam logic [4:0] MCODE_HI = 5'b00001;
endpackage

// File: rtl/conv_rd_sync.sv
module conv_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic scl_prev,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    localparam int SW = (STAGES < 2) ? 2 : STAGES;

    logic [SW-1:0] scl_sh_d, scl_sh_q, sda_sh_d, sda_sh_q;
    logic          scl_p_d, scl_p_q, sda_p_d, sda_p_q;

    always_comb begin
        scl_sh_d = {scl_sh_q[SW-2:0], scl_in};
        sda_sh_d = {sda_sh_q[SW-2:0], sda_in};
        scl_p_d  = scl_sh_q[SW-1];
        sda_p_d  = sda_sh_q[SW-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= scl_sh_d;
            sda_sh_q <= sda_sh_d;
            scl_p_q  <= scl_p_d;
            sda_p_q  <= sda_p_d;
        end
    end

    assign scl_s    = scl_sh_q[SW-1];
    assign sda_s    = sda_sh_q[SW-1];
    assign scl_prev = scl_p_q;
    assign scl_rise = scl_s & ~scl_p_q;
    assign scl_fall = ~scl_s & scl_p_q;
    assign start_p  = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_p   = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/conv_rd_fsm.sv
module conv_rd_fsm
    import conv_rd_pkg::*;
#(
    parameter int                 STRAP_W = 4,
    parameter logic [6-STRAP_W:0] ADDR_HI = 3'b011,
    parameter int                 DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_prev,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic [STRAP_W-1:0] strap,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              conv_start,
    output logic              hs_mode,
    output logic              ref_keep
);
    localparam int NBYTES = DATA_W / 8;
    localparam int BSEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef struct packed {
        st_e              st;
        logic [3:0]       bcnt;
        logic [7:0]       rx;
        logic [DATA_W-1:0] tx;
        logic [BSEL_W-1:0] bsel;
        logic             mack;
        logic             sda_oe;
        logic             scl_oe;
        logic             cstart;
        logic             hs;
        logic             refkeep;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.cstart = 1'b0;
        unique case (r_q.st)
            S_ADDR: begin
                if (scl_rise && r_q.bcnt < 4'd8) begin
                    r_d.rx   = {r_q.rx[6:0], sda_s};
                    r_d.bcnt = r_q.bcnt + 4'd1;
                end else if (scl_fall && r_q.bcnt == 4'd8) begin
                    if (r_q.rx[7:1] == {ADDR_HI, strap}) begin
                        r_d.st      = S_AACK;
                        r_d.sda_oe  = 1'b1;
                        r_d.refkeep = r_q.rx[0];
                    end else if (r_q.rx[7:3] == MCODE_HI) begin
                        r_d.st = S_MCODE;
                    end else begin
                        r_d.st = S_IDLE;
                    end
                end
            end
            S_AACK: if (scl_fall) begin
                r_d.st     = S_CONV;
                r_d.sda_oe = 1'b0;
                r_d.scl_oe = 1'b1;
                r_d.cstart = 1'b1;
            end
            S_MCODE: if (scl_fall) begin
                r_d.st = S_IDLE;
                r_d.hs = 1'b1;
            end
            S_CONV: if (conv_done) begin
                r_d.tx     = conv_data;
                r_d.sda_oe = ~conv_data[DATA_W-1];
                r_d.scl_oe = 1'b0;
                r_d.st     = S_TX;
                r_d.bcnt   = 4'd0;
                r_d.bsel   = '0;
            end
            S_TX: if (scl_fall) begin
                r_d.tx   = {r_q.tx[DATA_W-2:0], 1'b0};
                r_d.bcnt = r_q.bcnt + 4'd1;
                if (r_q.bcnt == 4'd7) begin
                    r_d.st     = S_RACK;
                    r_d.sda_oe = 1'b0;
                end else begin
                    r_d.sda_oe = ~r_q.tx[DATA_W-2];
                end
            end
            S_RACK: begin
                if (scl_rise) begin
                    r_d.mack = ~sda_s;
                end else if (scl_fall) begin
                    if (!r_q.mack) begin
                        r_d.st = S_IDLE;
                    end else if (r_q.bsel == BSEL_W'(NBYTES - 1)) begin
                        r_d.st     = S_CONV;
                        r_d.scl_oe = 1'b1;
                        r_d.cstart = 1'b1;
                    end else begin
                        r_d.st     = S_TX;
                        r_d.bsel   = r_q.bsel + 1'b1;
                        r_d.bcnt   = 4'd0;
                        r_d.sda_oe = ~r_q.tx[DATA_W-1];
                    end
                end
            end
            default: ;
        endcase
        if (start_p) begin
            r_d.st     = S_ADDR;
            r_d.bcnt   = 4'd0;
            r_d.sda_oe = 1'b0;
            r_d.scl_oe = 1'b0;
            r_d.cstart = 1'b0;
        end
        if (stop_p) begin
            r_d.st     = S_IDLE;
            r_d.sda_oe = 1'b0;
            r_d.scl_oe = 1'b0;
            r_d.cstart = 1'b0;
            r_d.hs     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.refkeep <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe     = r_q.sda_oe;
    assign scl_oe     = r_q.scl_oe;
    assign conv_start = r_q.cstart;
    assign hs_mode    = r_q.hs;
    assign ref_keep   = r_q.refkeep;

    // R3
    stretch_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> scl_oe);
    // R3
    start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R3
    release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> $past(conv_done));
    // R8
    stop_clears_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !hs_mode);
    // R10
    sda_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && scl_prev && $past(scl_s) && !$past(start_p) && !$past(stop_p))
        |-> $stable(sda_oe));
    // R3
    no_data_while_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !sda_oe);
endmodule

// File: rtl/conv_rd_slave.sv
module conv_rd_slave #(
    parameter int         SYNC_STAGES = 2,
    parameter int         STRAP_W     = 4,
    parameter logic [6-STRAP_W:0] ADDR_HI = 3'b011,
    parameter int         DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic [STRAP_W-1:0] strap,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              hs_mode,
    output logic              ref_keep_on
);
    logic scl_s, scl_prev, sda_s, scl_rise, scl_fall, start_p, stop_p;

    conv_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .scl_prev (scl_prev),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    conv_rd_fsm #(
        .STRAP_W (STRAP_W),
        .ADDR_HI (ADDR_HI),
        .DATA_W  (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .scl_prev   (scl_prev),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_p    (start_p),
        .stop_p     (stop_p),
        .strap      (strap),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .sda_oe     (sda_pull),
        .scl_oe     (scl_pull),
        .conv_start (conv_start),
        .hs_mode    (hs_mode),
        .ref_keep   (ref_keep_on)
    );
endmodule

// File: tb/sim_conv_rd_slave.sv
module sim_conv_rd_slave;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic        scl_line, sda_line;
    logic        scl_pull, sda_pull, conv_start, hs_mode, ref_keep_on;
    logic [3:0]  strap = 4'h5;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = 16'h0;
    logic [15:0] conv_val = 16'h0;
    int          n_chk = 0, n_bad = 0, conv_cnt = 0, conv_idx = 0, r10_bad = 0;
    logic        prev_scl = 1'b1, prev_sda_pull = 1'b0;

    always #2 clk = ~clk;

    assign scl_line = m_scl & ~scl_pull;
    assign sda_line = m_sda & ~sda_pull;

    conv_rd_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .strap(strap),
        .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
        .hs_mode(hs_mode), .ref_keep_on(ref_keep_on)
    );

    function automatic logic [7:0] addr_byte(input logic [3:0] s, input logic rw);
        return {3'b011, s, rw};
    endfunction

    function automatic logic [7:0] result_byte(input logic [15:0] v, input int idx);
        return (idx == 0) ? v[15:8] : v[7:0];
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; hw(H);
        m_scl = 1'b1; wait_high(); hw(H);
        m_sda = 1'b0; hw(H);
        m_scl = 1'b0; hw(H);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; hw(H);
        m_scl = 1'b1; wait_high(); hw(H);
        m_sda = 1'b1; hw(H);
    endtask

    task automatic m_bit(input logic b, output logic got);
        m_sda = b; hw(H);
        m_scl = 1'b1; wait_high(); hw(H/2);
        got = sda_line; hw(H/2);
        m_scl = 1'b0; hw(H);
    endtask

    task automatic m_byte_out(input logic [7:0] v, output logic ackbit);
        logic g;
        for (int i = 7; i >= 0; i--) m_bit(v[i], g);
        m_sda = 1'b1;
        m_bit(1'b1, ackbit);
    endtask

    task automatic m_byte_in(output logic [7:0] v, input logic nack);
        logic g;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            m_bit(1'b1, g);
            v = {v[6:0], g};
        end
        m_bit(nack, g);
        m_sda = 1'b1;
    endtask

    // Conversion engine model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && conv_start) begin
                int lat;
                conv_cnt++;
                lat = 2 + int'($urandom_range(0, 40));
                hw(lat);
                check(scl_pull, 1, "R3 clock stretched during conversion");
                if (conv_idx == 0)      conv_val = 16'hFFFF;
                else if (conv_idx == 1) conv_val = 16'h0000;
                else                    conv_val = 16'($urandom);
                conv_idx++;
                conv_data = conv_val;
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
                check(scl_pull, 0, "R3 clock released after done");
            end
        end
    end

    // R10 monitor: data enable must not move while the line clock stays high
    always @(negedge clk) begin
        if (rst_n && scl_line && prev_scl && (sda_pull != prev_sda_pull) && !sda_pull == 1'b0)
            r10_bad++;
        prev_scl      <= scl_line;
        prev_sda_pull <= sda_pull;
    end

    task automatic do_read(input logic rw, input int nres, input logic early_nack);
        logic       a;
        logic [7:0] b;
        int         c0;
        m_start();
        c0 = conv_cnt;
        m_byte_out(addr_byte(strap, rw), a);
        check(a, 0, "R1 address ACK");
        check(conv_cnt, c0 + 1, "R3 conversion started");
        check(ref_keep_on, rw, "R9 power flag latched");
        for (int r = 0; r < nres; r++) begin
            m_byte_in(b, early_nack);
            check(b, result_byte(conv_val, 0), "R4 first byte");
            if (early_nack) begin
                hw(4*H);
                check(conv_cnt, c0 + 1, "R6 no conversion after first-byte NACK");
                check(sda_pull, 0, "R6 data released after first-byte NACK");
                return;
            end
            m_byte_in(b, (r == nres - 1));
            check(b, result_byte(conv_val, 1), "R4 second byte");
        end
        hw(4*H);
        check(conv_cnt, c0 + nres, "R5 conversions per ACKed pair");
        check({scl_pull, sda_pull}, 0, "R5 bus released after NACK");
    endtask

    task automatic do_mismatch(input logic rw);
        logic       a, g;
        logic [3:0] ws;
        int         c0, kept, highs;
        ws = strap ^ (4'($urandom_range(1, 15)));
        kept = ref_keep_on;
        m_start();
        c0 = conv_cnt;
        m_byte_out(addr_byte(ws, rw), a);
        check(a, 1, "R2 no ACK for foreign address");
        highs = 0;
        for (int i = 0; i < 9; i++) begin
            m_bit(1'b1, g);
            highs += int'(g);
        end
        check(highs, 9, "R2 SDA left undriven after mismatch");
        check(conv_cnt, c0, "R2 no conversion on mismatch");
        check(ref_keep_on, kept, "R9 flag unchanged by mismatch");
        m_stop();
    endtask

    task automatic do_mcode();
        logic a;
        m_start();
        m_byte_out({5'b00001, 3'($urandom)}, a);
        check(a, 1, "R7 master code NACK");
        check(hs_mode, 1, "R7 high-speed mode entered");
        do_read(1'($urandom), 1, 1'b0);
        check(hs_mode, 1, "R8 mode kept across repeated START");
        m_stop();
        hw(8);
        check(hs_mode, 0, "R8 STOP returns to fast mode");
    endtask

    task automatic do_abort();
        logic g;
        int   c0;
        m_start();
        for (int i = 0; i < 4; i++) m_bit(1'b0, g);
        c0 = conv_cnt;
        do_read(1'b1, 1, 1'b0);
        check(conv_cnt, c0 + 1, "R11 address after mid-byte START accepted");
        m_stop();
    endtask

    initial begin
        // watchdog
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        hw(5);
        rst_n = 1'b1;
        hw(5);
        check(sda_pull, 0, "R10 reset: data released");
        check(scl_pull, 0, "R3 reset: clock released");
        check(conv_start, 0, "R3 reset: no request");
        check(hs_mode, 0, "R8 reset mode");
        check(ref_keep_on, 1, "R9 reset flag");

        // directed corners
        do_read(1'b0, 2, 1'b0);
        m_stop();
        do_read(1'b1, 1, 1'b1);
        m_stop();
        do_mismatch(1'b0);
        do_mcode();
        do_abort();

        // random mix
        for (int t = 0; t < 24; t++) begin
            int kind;
            strap = 4'($urandom);
            hw(H);
            kind = int'($urandom_range(0, 4));
            case (kind)
                0, 1: begin do_read(1'($urandom), int'($urandom_range(1, 3)), 1'b0); m_stop(); end
                2: begin do_read(1'($urandom), 1, 1'b1); m_stop(); end
                3: do_mismatch(1'($urandom));
                default: do_mcode();
            endcase
        end

        check(r10_bad, 0, "R10 data changes only while clock low");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule